// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block tells a memory controller which DRAM row holds a given address. Software programs one 16-bit limit per row. Each limit counts in 4 MB units and holds the running total of memory in that row and in every row below it, so the limits never decrease. Any row can be left empty by giving it the same limit as the row below it. Such a row has a zero-width window, so the decoder skips it.

The lookup address comes from the controller's own memory space, with any programmed gaps already removed. The decoder drops the low 22 bits of the address and compares the remaining page number with each row's window, lower limit inclusive and upper limit exclusive. It registers the lowest matching row and a hit flag. A byte-wide configuration port reaches the limits at offsets 60h to 6Fh. A mode input narrows the decode to rows 0 to 3 for four-row parts. The decode has no sequencing, so there is no state machine: the registered limits and the registered lookup result are the only state.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every one of the eight limits holds 0001h. A read of offset 60h+2N returns 01h and a read of 61h+2N returns 00h.
- R2: When `cfg_wr_en` is high at a rising edge, the limit byte at `cfg_addr` takes `cfg_wdata`. Limit N has its low byte at 60h+2N and its high byte at 61h+2N. `cfg_rdata` always shows the byte at `cfg_addr` without delay.
- R3: A write to an offset below 60h or above 6Fh changes no limit, and a read of such an offset returns 00h.
- R4: A lookup result appears on `lk_hit`/`lk_row` after the rising edge that samples `lk_addr`. It is based on the limits as they stood before that edge, so a write takes effect on lookups from the following cycle.
- R5: The page is `lk_addr[31:22]`. Row N matches when the page is at or above limit N-1 and below limit N, where limit -1 is taken as 0. The decoder reports the lowest matching row with `lk_hit`=1. Bits 21:0 of the address have no effect.
- R6: A row whose limit equals the limit of the row below it is never reported.
- R7: A page at or above the final limit gives `lk_hit`=0 and `lk_row`=0.
- R8: With `mode_eight`=0 only rows 0 to 3 take part, and the final limit is limit 3. Limits 4 to 7 are ignored even when they hold larger values.
- R9: With `mode_eight`=1 all eight rows take part, and the final limit is limit 7.
- R10: Limits are compared at their full 16 bits. A limit above 03FFh covers every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte at `cfg_addr` |
| mode_eight | input | 1 | 1 = eight-row decode, 0 = four-row decode |
| lk_addr | input | 32 | Controller-relative, gap-free address |
| lk_hit | output | 1 | Registered: address lies in a populated row |
| lk_row | output | 3 | Registered: selected row, 0 on a miss |

## Verification
The reset limits are tried first. Page 0 must hit row 0 and page 1 must miss, which separates the inclusive lower bound from the exclusive upper bound. A cumulative layout with empty rows in the middle and at the top is then probed on both sides of every boundary, with varying low address bits. These probes show whether empty rows are skipped, whether the lowest row wins, and whether the offset bits are ignored. The same layout is decoded again in four-row mode with larger upper limits, to show that rows 4 to 7 are ignored. A write in the same cycle as a lookup separates old-limit from new-limit timing, and a limit above the page range checks the full-width compare.

// File: rtl/drd_pkg.sv
package drd_pkg;
    localparam int unsigned DRD_ROWS        = 8;
    localparam int unsigned DRD_LIMIT_W     = 16;
    localparam int unsigned DRD_ADDR_W      = 32;
    localparam int unsigned DRD_GRAN_SHIFT  = 22;
    localparam int unsigned DRD_CFG_AW      = 8;
    localparam logic [7:0]  DRD_CFG_BASE    = 8'h60;
    localparam logic [15:0] DRD_RESET_LIMIT = 16'h0001;

    typedef logic [DRD_LIMIT_W-1:0] drd_limit_t;
endpackage

// File: rtl/drd_limit_regs.sv
module drd_limit_regs #(
    parameter int unsigned           ROWS        = drd_pkg::DRD_ROWS,
    parameter int unsigned           LIMIT_W     = drd_pkg::DRD_LIMIT_W,
    parameter int unsigned           CFG_AW      = drd_pkg::DRD_CFG_AW,
    parameter logic [CFG_AW-1:0]     CFG_BASE    = drd_pkg::DRD_CFG_BASE,
    parameter logic [LIMIT_W-1:0]    RESET_LIMIT = drd_pkg::DRD_RESET_LIMIT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr_en,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [7:0]                      cfg_wdata,
    output logic [7:0]                      cfg_rdata,
    output logic [ROWS-1:0][LIMIT_W-1:0]    limits
);
    localparam int unsigned BYTES_PER = LIMIT_W / 8;
    localparam int unsigned SPAN      = ROWS * BYTES_PER;
    localparam logic [CFG_AW:0] END_ADDR = {1'b0, CFG_BASE} + (CFG_AW+1)'(SPAN);

    logic              in_range;
    logic [CFG_AW-1:0] offset;

    assign in_range = ({1'b0, cfg_addr} >= {1'b0, CFG_BASE}) && ({1'b0, cfg_addr} < END_ADDR);
    assign offset   = cfg_addr - CFG_BASE;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar b = 0; b < BYTES_PER; b++) begin : g_byte
            localparam logic [CFG_AW-1:0] MY_OFF = CFG_AW'(r * BYTES_PER + b);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    limits[r][b*8 +: 8] <= RESET_LIMIT[b*8 +: 8];
                end else if (cfg_wr_en && in_range && (offset == MY_OFF)) begin
                    limits[r][b*8 +: 8] <= cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        for (int r = 0; r < ROWS; r++) begin
            for (int b = 0; b < BYTES_PER; b++) begin
                if (in_range && (offset == CFG_AW'(r * BYTES_PER + b))) begin
                    cfg_rdata = limits[r][b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/drd_row_window.sv
module drd_row_window #(
    parameter int unsigned ROWS    = drd_pkg::DRD_ROWS,
    parameter int unsigned LIMIT_W = drd_pkg::DRD_LIMIT_W,
    parameter int unsigned PAGE_W  = 10
) (
    input  logic [PAGE_W-1:0]              page,
    input  logic [ROWS-1:0][LIMIT_W-1:0]   limits,
    input  logic                           mode_eight,
    output logic [ROWS-1:0]                in_win
);
    localparam int unsigned HALF  = ROWS / 2;
    localparam int unsigned CMP_W = ((PAGE_W > LIMIT_W) ? PAGE_W : LIMIT_W) + 1;

    logic [CMP_W-1:0] page_ext;
    assign page_ext = CMP_W'(page);

    for (genvar r = 0; r < ROWS; r++) begin : g_win
        logic [CMP_W-1:0] lower;
        logic [CMP_W-1:0] upper;
        logic             row_en;

        if (r == 0) begin : g_first
            assign lower = '0;
        end else begin : g_rest
            assign lower = CMP_W'(limits[r-1]);
        end

        if (r < HALF) begin : g_always
            assign row_en = 1'b1;
        end else begin : g_upper
            assign row_en = mode_eight;
        end

        assign upper     = CMP_W'(limits[r]);
        assign in_win[r] = row_en && (page_ext >= lower) && (page_ext < upper);
    end
endmodule

// File: rtl/drd_row_select.sv
module drd_row_select #(
    parameter int unsigned ROWS  = drd_pkg::DRD_ROWS,
    parameter int unsigned IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROWS-1:0]  in_win,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_row
);
    logic             nxt_hit;
    logic [IDX_W-1:0] nxt_row;

    always_comb begin
        nxt_hit = 1'b0;
        nxt_row = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (in_win[r]) begin
                nxt_hit = 1'b1;
                nxt_row = IDX_W'(r);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit <= 1'b0;
            lk_row <= '0;
        end else begin
            lk_hit <= nxt_hit;
            lk_row <= nxt_row;
        end
    end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
    parameter int unsigned ROWS       = drd_pkg::DRD_ROWS,
    parameter int unsigned LIMIT_W    = drd_pkg::DRD_LIMIT_W,
    parameter int unsigned ADDR_W     = drd_pkg::DRD_ADDR_W,
    parameter int unsigned GRAN_SHIFT = drd_pkg::DRD_GRAN_SHIFT,
    parameter int unsigned CFG_AW     = drd_pkg::DRD_CFG_AW,
    parameter int unsigned IDX_W      = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mode_eight,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_row
);
    localparam int unsigned PAGE_W = ADDR_W - GRAN_SHIFT;

    logic [ROWS-1:0][LIMIT_W-1:0] limits;
    logic [ROWS-1:0]              in_win;
    logic [PAGE_W-1:0]            page;

    assign page = lk_addr[ADDR_W-1:GRAN_SHIFT];

    drd_limit_regs #(
        .ROWS    (ROWS),
        .LIMIT_W (LIMIT_W),
        .CFG_AW  (CFG_AW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .limits    (limits)
    );

    drd_row_window #(
        .ROWS    (ROWS),
        .LIMIT_W (LIMIT_W),
        .PAGE_W  (PAGE_W)
    ) win_i (
        .page       (page),
        .limits     (limits),
        .mode_eight (mode_eight),
        .in_win     (in_win)
    );

    drd_row_select #(
        .ROWS  (ROWS),
        .IDX_W (IDX_W)
    ) sel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_win (in_win),
        .lk_hit (lk_hit),
        .lk_row (lk_row)
    );
endmodule

// File: rtl/drd_checker.sv
module drd_checker #(
    parameter int unsigned ROWS       = drd_pkg::DRD_ROWS,
    parameter int unsigned LIMIT_W    = drd_pkg::DRD_LIMIT_W,
    parameter int unsigned ADDR_W     = drd_pkg::DRD_ADDR_W,
    parameter int unsigned GRAN_SHIFT = drd_pkg::DRD_GRAN_SHIFT,
    parameter int unsigned CFG_AW     = drd_pkg::DRD_CFG_AW,
    parameter int unsigned IDX_W      = $clog2(ROWS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr_en,
    input logic [CFG_AW-1:0]             cfg_addr,
    input logic [7:0]                    cfg_wdata,
    input logic                          mode_eight,
    input logic [ADDR_W-1:0]             lk_addr,
    input logic                          lk_hit,
    input logic [IDX_W-1:0]              lk_row,
    input logic [ROWS-1:0][LIMIT_W-1:0]  limits
);
    localparam int unsigned SPAN = ROWS * (LIMIT_W / 8);
    localparam int unsigned HALF = ROWS / 2;

    logic [ROWS*LIMIT_W-1:0]      flat;
    logic [ROWS-1:0][LIMIT_W-1:0] limits_q;
    logic [ADDR_W-1:0]            addr_q;
    logic                         mode_q;
    logic                         wr_in;
    int unsigned                  wr_off;
    logic [LIMIT_W:0]             page_q;
    logic [LIMIT_W:0]             lo_q;
    logic [LIMIT_W:0]             hi_q;

    assign flat   = limits;
    assign wr_off = int'(cfg_addr) - int'(drd_pkg::DRD_CFG_BASE);
    assign wr_in  = (int'(cfg_addr) >= int'(drd_pkg::DRD_CFG_BASE)) &&
                    (int'(cfg_addr) < int'(drd_pkg::DRD_CFG_BASE) + int'(SPAN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limits_q <= '0;
            addr_q   <= '0;
            mode_q   <= 1'b0;
        end else begin
            limits_q <= limits;
            addr_q   <= lk_addr;
            mode_q   <= mode_eight;
        end
    end

    always_comb begin
        page_q = (LIMIT_W+1)'(addr_q[ADDR_W-1:GRAN_SHIFT]);
        hi_q   = (LIMIT_W+1)'(limits_q[lk_row]);
        lo_q   = '0;
        if (lk_row != '0) lo_q = (LIMIT_W+1)'(limits_q[lk_row - 1'b1]);
    end

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (limits == {ROWS{drd_pkg::DRD_RESET_LIMIT}})); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && wr_in) |=> (flat[$past(wr_off)*8 +: 8] == $past(cfg_wdata))); // R2

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !wr_in) |=> $stable(limits)); // R3

    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((page_q >= lo_q) && (page_q < hi_q))); // R5

    AST_EMPTY_NEVER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lo_q != hi_q)); // R6

    AST_MISS_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_row == '0)); // R7

    AST_FOUR_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !mode_q) |-> (int'(lk_row) < int'(HALF))); // R8
endmodule

bind dram_row_decoder drd_checker #(
    .ROWS       (ROWS),
    .LIMIT_W    (LIMIT_W),
    .ADDR_W     (ADDR_W),
    .GRAN_SHIFT (GRAN_SHIFT),
    .CFG_AW     (CFG_AW),
    .IDX_W      (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .mode_eight (mode_eight),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .lk_row     (lk_row),
    .limits     (limits)
);

// File: tb/dram_row_decoder_tb_top.sv
module dram_row_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        mode_eight = 1'b1;
    logic [31:0] lk_addr = 32'h0;
    logic        lk_hit;
    logic [2:0]  lk_row;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_row_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_eight(mode_eight),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_row(lk_row)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_row(logic [9:0] page, logic eight);
        int n = eight ? 8 : 4;
        for (int r = 0; r < n; r++) begin
            logic [16:0] lo = (r == 0) ? 17'd0 : {1'b0, model[r-1]};
            logic [16:0] hi = {1'b0, model[r]};
            if ({7'd0, page} >= lo && {7'd0, page} < hi) return {1'b1, 3'(r)};
        end
        return 4'b0000;
    endfunction

    task automatic cfg_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a >= 8'h60 && a <= 8'h6F) begin
            if (a[0]) model[(a - 8'h60) >> 1][15:8] = d;
            else      model[(a - 8'h60) >> 1][7:0]  = d;
        end
    endtask

    task automatic set_limit(int n, logic [15:0] v);
        cfg_write(8'(8'h60 + 2*n), v[7:0]);
        cfg_write(8'(8'h61 + 2*n), v[15:8]);
    endtask

    task automatic cfg_read(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, {24'd0, cfg_rdata}, {24'd0, exp});
    endtask

    task automatic lookup(string req, logic [9:0] page, logic [21:0] low);
        logic [3:0] e;
        @(negedge clk);
        lk_addr = {page, low};
        e = expect_row(page, mode_eight);
        @(negedge clk);
        chk(req, {30'd0, lk_hit, 1'b0} | 32'(lk_row) << 4, {30'd0, e[3], 1'b0} | 32'(e[2:0]) << 4);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) begin
            cfg_read("R1 low byte", 8'(8'h60 + 2*i), 8'h01);
            cfg_read("R1 high byte", 8'(8'h61 + 2*i), 8'h00);
        end
        lookup("R5 page0 in row0", 10'd0, 22'h3FFFFF);
        lookup("R7 page1 beyond", 10'd1, 22'h000000);
    endtask

    task automatic t_regs;
        set_limit(3, 16'hA55A);
        cfg_read("R2 low byte", 8'h66, 8'h5A);
        cfg_read("R2 high byte", 8'h67, 8'hA5);
        cfg_write(8'h5F, 8'hEE);
        cfg_write(8'h70, 8'hEE);
        cfg_read("R3 read below", 8'h5F, 8'h00);
        cfg_read("R3 read above", 8'h70, 8'h00);
        cfg_read("R3 lim0 untouched", 8'h60, 8'h01);
        cfg_read("R3 lim7 untouched", 8'h6F, 8'h00);
        cfg_read("R3 lim7 low untouched", 8'h6E, 8'h01);
    endtask

    task automatic t_layout;
        logic [15:0] lim [8] = '{16'd2, 16'd2, 16'd5, 16'd6, 16'd6, 16'd10, 16'd10, 16'd12};
        for (int i = 0; i < 8; i++) set_limit(i, lim[i]);
        mode_eight = 1'b1;
        lookup("R5 page0", 10'd0, 22'h123456);
        lookup("R5 page1 top", 10'd1, 22'h3FFFFF);
        lookup("R6 page2 skips empty row1", 10'd2, 22'h000000);
        lookup("R5 page4", 10'd4, 22'h2AAAAA);
        lookup("R5 page5 row3", 10'd5, 22'h000001);
        lookup("R6 page6 skips row4", 10'd6, 22'h000000);
        lookup("R5 page9", 10'd9, 22'h3FFFFF);
        lookup("R9 page10 row7", 10'd10, 22'h000000);
        lookup("R9 page11", 10'd11, 22'h3FFFFF);
        lookup("R7 page12 miss", 10'd12, 22'h000000);
        lookup("R7 page1023 miss", 10'd1023, 22'h3FFFFF);
    endtask

    task automatic t_four_row;
        mode_eight = 1'b0;
        lookup("R8 page5 row3", 10'd5, 22'h000000);
        lookup("R8 page6 miss", 10'd6, 22'h000000);
        lookup("R8 page10 miss", 10'd10, 22'h111111);
        lookup("R8 page0", 10'd0, 22'h000000);
        mode_eight = 1'b1;
        lookup("R9 page6 back in eight", 10'd6, 22'h000000);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        lk_addr = {10'd12, 22'h0};
        cfg_wr_en = 1'b1; cfg_addr = 8'h6E; cfg_wdata = 8'd13;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk("R4 same-cycle uses old limit", {31'd0, lk_hit}, 32'd0);
        model[7][7:0] = 8'd13;
        @(negedge clk);
        chk("R4 next cycle uses new limit hit", {31'd0, lk_hit}, 32'd1);
        chk("R4 next cycle row", {29'd0, lk_row}, 32'd7);
    endtask

    task automatic t_wide;
        set_limit(7, 16'h0400);
        lookup("R10 top page hit", 10'd1023, 22'h3FFFFF);
        set_limit(7, 16'hFFFF);
        lookup("R10 large limit hit", 10'd700, 22'h000000);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'h0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 lk_hit at reset", {31'd0, lk_hit}, 32'd0);
        chk("R1 lk_row at reset", {29'd0, lk_row}, 32'd0);
        t_reset;
        t_regs;
        t_layout;
        t_four_row;
        t_write_timing;
        t_wide;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule